// File: doc/BRIEF.md
# Stepped Voltage-ID Reference Controller

This block turns a 5-bit voltage identification code into a digital reference setpoint for a multi-phase buck controller. The setpoint is an index in 25 mV units above 1.100 V, and it drives an external DAC. The code is read only when the PWM sequencer pulses its start-of-cycle strobe. A new code must hold for one more cycle before it is taken. The setpoint then walks toward the new target one step at a time, so the output voltage never jumps during operation.

The all-ones code means that no load is present. The block reports it as a shutdown request and drops its target-valid flag. When a real code is accepted after shutdown, the setpoint is loaded straight to the target, because start-up ramping belongs to the soft-start logic. A busy flag tells the sequencer that a ramp is in progress.

Top module: `vid_ref_stepper`

## Requirements
- R1: After reset, the setpoint is 0, the target-valid flag is low, the shutdown request is high and busy is low. The block behaves as if the all-ones code had already been accepted.
- R2: An accepted code c (not all ones) gives the target index 30 − c. So 11110 gives index 0 (1.100 V), 00000 gives index 30 (1.850 V), and each step of the index is 25 mV.
- R3: The code input is sampled only on a clock edge where the strobe is high. A code change between strobes leaves every output unchanged until the strobe.
- R4: A code first seen at one strobe is accepted at the next strobe only if it is still the same. A code present for a single strobe is never accepted.
- R5: After acceptance, the setpoint moves by exactly one index toward the target at every second strobe, in either direction, and stops at the target. A change of n steps completes at the (1+2n)-th strobe after the one that first saw the code.
- R6: Busy rises at the strobe that accepts a code whose target differs from the setpoint. It falls at the strobe where the setpoint reaches the target. Busy is never high without a valid target.
- R7: Accepting the all-ones code raises the shutdown request, lowers target-valid, clears busy and holds the setpoint.
- R8: Accepting a valid code while in shutdown loads the setpoint directly with the target, with busy low.
- R9: A code change during a ramp passes the same one-strobe stability check. The ramp toward the old target continues meanwhile, then goes on from the current setpoint toward the new target with no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock strobe at the start of each phase-1 switching cycle |
| vid_code | input | 5 | Voltage identification code |
| setpt | output | 5 | Reference setpoint index, 25 mV per step above 1.100 V |
| tgt_valid | output | 1 | The accepted code is a real voltage |
| shdn_req | output | 1 | The accepted code is the no-load code |
| ramp_busy | output | 1 | The setpoint is still moving toward the target |

## Verification
The bench builds the block with its default parameters: a 5-bit code, one strobe of stability hold and two strobes per step. Under these settings, the full 30-step descent from 1.850 V to 1.100 V takes 60 strobes, which stays short enough to check against the model at every strobe. Both ends of the code range, a one-strobe glitch, a retarget partway through a ramp and both shutdown transitions are therefore all within reach of directed scenarios. The strobe is spaced several clocks apart, so the bench can also show that code changes between strobes have no effect.

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper #(
  parameter int VID_W    = 5,
  parameter int HOLD_CYC = 1,
  parameter int STEP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic [VID_W-1:0] vid_code,
  output logic [VID_W-1:0] setpt,
  output logic             tgt_valid,
  output logic             shdn_req,
  output logic             ramp_busy
);
  localparam logic [VID_W-1:0] OFF_CODE = '1;
  localparam logic [VID_W-1:0] TOP_IDX  = OFF_CODE - 1'b1;
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int SW = $clog2(STEP_CYC + 1);

  logic [VID_W-1:0] samp_q, acc_q, sp_q;
  logic [HW-1:0]    hold_cnt;
  logic [SW-1:0]    step_cnt;
  logic             busy_q;

  wire seen_new = cyc_start && (vid_code != samp_q);
  wire accept   = cyc_start && !seen_new && (samp_q != acc_q) && (hold_cnt == HW'(HOLD_CYC - 1));
  wire [VID_W-1:0] new_tgt = TOP_IDX - samp_q;
  wire [VID_W-1:0] cur_tgt = TOP_IDX - acc_q;
  wire [VID_W-1:0] sp_next = (cur_tgt > sp_q) ? sp_q + 1'b1 : sp_q - 1'b1;
  wire step_due = (step_cnt == SW'(STEP_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q   <= OFF_CODE;
      acc_q    <= OFF_CODE;
      sp_q     <= '0;
      busy_q   <= 1'b0;
      hold_cnt <= '0;
      step_cnt <= '0;
    end else if (cyc_start) begin
      if (seen_new) begin
        samp_q   <= vid_code;
        hold_cnt <= '0;
      end else if (samp_q != acc_q && !accept) begin
        hold_cnt <= hold_cnt + 1'b1;
      end

      if (accept) begin
        acc_q    <= samp_q;
        step_cnt <= '0;
        hold_cnt <= '0;
        if (samp_q == OFF_CODE) begin
          busy_q <= 1'b0;
        end else if (acc_q == OFF_CODE) begin
          sp_q   <= new_tgt;
          busy_q <= 1'b0;
        end else begin
          busy_q <= (new_tgt != sp_q);
        end
      end else if (busy_q) begin
        if (step_due) begin
          step_cnt <= '0;
          sp_q     <= sp_next;
          busy_q   <= (sp_next != cur_tgt);
        end else begin
          step_cnt <= step_cnt + 1'b1;
        end
      end
    end
  end

  assign setpt     = sp_q;
  assign tgt_valid = (acc_q != OFF_CODE);
  assign shdn_req  = (acc_q == OFF_CODE);
  assign ramp_busy = busy_q;

  // R3
  setpt_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(setpt));

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && $past(tgt_valid)) |->
      (setpt == $past(setpt) || setpt == $past(setpt) + 1'b1 || setpt == $past(setpt) - 1'b1));

  // R6
  busy_needs_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_busy |-> tgt_valid);

  // R6
  idle_at_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !ramp_busy) |-> (setpt == cur_tgt));

  // R4
  accept_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_valid) |-> $past(cyc_start));
endmodule

// File: tb/test_vid_ref_stepper.sv
module test_vid_ref_stepper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_start = 1'b0;
  logic [4:0] vid_code = 5'b11111;
  logic [4:0] setpt;
  logic       tgt_valid, shdn_req, ramp_busy;

  int errors = 0;
  int checks = 0;
  int exp_sp = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vid_ref_stepper i_vid_ref_stepper (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .vid_code(vid_code),
    .setpt(setpt), .tgt_valid(tgt_valid), .shdn_req(shdn_req), .ramp_busy(ramp_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) cyc_start = 1'b1;
    @(negedge clk) cyc_start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_code(input logic [4:0] c);
    @(negedge clk) vid_code = c;
  endtask

  task automatic t_reset();
    check("R1 setpt", setpt, 0);
    check("R1 tgt_valid", tgt_valid, 0);
    check("R1 shdn_req", shdn_req, 1);
    check("R1 busy", ramp_busy, 0);
  endtask

  task automatic t_startup(input logic [4:0] c);
    set_code(c);
    strobe();
    check("R4 not yet accepted shdn", shdn_req, 1);
    check("R4 not yet accepted setpt", setpt, exp_sp);
    strobe();
    exp_sp = 30 - c;
    check("R8 load from shutdown", setpt, exp_sp);
    check("R8 busy low", ramp_busy, 0);
    check("R2 tgt_valid", tgt_valid, 1);
  endtask

  task automatic t_between_strobes(input logic [4:0] c);
    set_code(c);
    repeat (6) @(negedge clk);
    check("R3 no change between strobes", setpt, exp_sp);
    check("R3 busy unchanged", ramp_busy, 0);
  endtask

  task automatic t_ramp(input logic [4:0] c, input string tag);
    int tgt = 30 - c;
    int n = 0;
    set_code(c);
    strobe();
    check({tag, " R4 first strobe holds"}, setpt, exp_sp);
    check({tag, " R4 first strobe no busy"}, ramp_busy, 0);
    strobe();
    check({tag, " R6 busy at accept"}, ramp_busy, (exp_sp != tgt) ? 1 : 0);
    check({tag, " R5 no move at accept"}, setpt, exp_sp);
    while (exp_sp != tgt) begin
      strobe();
      check({tag, " R5 hold strobe"}, setpt, exp_sp);
      strobe();
      exp_sp = (tgt > exp_sp) ? exp_sp + 1 : exp_sp - 1;
      n++;
      check({tag, " R5 step"}, setpt, exp_sp);
      check({tag, " R6 busy"}, ramp_busy, (exp_sp != tgt) ? 1 : 0);
    end
    check({tag, " R2 final index"}, setpt, tgt);
  endtask

  task automatic t_glitch(input logic [4:0] c, input logic [4:0] back);
    set_code(c);
    strobe();
    set_code(back);
    strobe();
    strobe();
    strobe();
    check("R4 glitch dropped setpt", setpt, exp_sp);
    check("R4 glitch dropped busy", ramp_busy, 0);
  endtask

  task automatic t_retarget();
    set_code(5'd2);
    strobe();
    strobe();
    check("R9 busy toward 28", ramp_busy, 1);
    strobe();
    strobe();
    exp_sp++;
    check("R9 first step", setpt, exp_sp);
    strobe();
    set_code(5'd11);
    strobe();
    exp_sp++;
    check("R9 old ramp continues during hold", setpt, exp_sp);
    strobe();
    check("R9 no jump at accept", setpt, exp_sp);
    check("R9 busy toward 19", ramp_busy, 1);
    strobe();
    check("R9 hold strobe", setpt, exp_sp);
    strobe();
    exp_sp--;
    check("R9 stepped back", setpt, 19);
    check("R9 busy cleared", ramp_busy, 0);
  endtask

  task automatic t_shutdown();
    set_code(5'b11111);
    strobe();
    check("R7 not yet", shdn_req, 0);
    strobe();
    check("R7 shdn_req", shdn_req, 1);
    check("R7 tgt_valid", tgt_valid, 0);
    check("R7 setpt held", setpt, exp_sp);
    check("R7 busy", ramp_busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_startup(5'b01110);
    t_between_strobes(5'b00110);
    t_ramp(5'b00110, "up");
    t_ramp(5'b01100, "down");
    t_glitch(5'b00001, 5'b01100);
    t_retarget();
    t_shutdown();
    t_startup(5'b00000);
    check("R2 top index 1.850V", setpt, 30);
    t_ramp(5'b11110, "full");
    check("R2 bottom index 1.100V", setpt, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule